// File: doc/BRIEF.md
# Block Memory Transfer Engine

This engine copies a run of bytes through a single-port memory interface. A start pulse loads a 16-bit source address, a 16-bit destination address, a 16-bit byte count and a 3-bit pattern code. The engine then spends one cycle reading a byte and the next cycle writing it, and repeats this until the count runs out. Finally it raises a one-cycle completion pulse.

There are five address patterns. In two of them the source and destination both walk upward or both walk downward. In one, the source walks upward while the destination stays fixed. The last two flip one side between a base address and base+1 on successive bytes, which suits a 16-bit register pair mapped at two adjacent byte addresses. Alongside the copy, the engine keeps a cost tally in abstract cycles: a fixed setup charge plus a fixed charge for each byte. The caller reads this tally once the transfer completes.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are low and `cost_o` is 0. While `busy_o` is low, no memory access is made.
- R2: Each byte uses one cycle with `mem_rd_o` high, then the next cycle with `mem_wr_o` high. During the write cycle, `mem_wdata_o` is the `mem_rdata_i` value sampled at the end of the read cycle. Read and write are never high together. The first read happens in the cycle after the accepting clock edge.
- R3: Pattern code 0: byte i is read from src+i and written to dst+i.
- R4: Pattern code 1: byte i is read from src-i and written to dst-i.
- R5: Pattern code 2: byte i is read from src+i, and every byte is written to dst.
- R6: Pattern code 3: byte i is read from src+i and written to dst+(i mod 2).
- R7: Pattern code 4: byte i is read from src+(i mod 2) and written to dst+i.
- R8: All address arithmetic wraps modulo 2^16, so 0xFFFF+1 is 0x0000 and 0x0000-1 is 0xFFFF.
- R9: A start with length 0 makes no memory access. It raises `done_o` in the cycle after the accepting edge and leaves `cost_o` at 17.
- R10: `done_o` is high for exactly one cycle, the cycle after the last write. `busy_o` is high from the cycle after the accepting edge through the `done_o` cycle.
- R11: `cost_o` equals 17 + 6*N in the `done_o` cycle and holds that value until the next accepted start, where N is the length.
- R12: A start is accepted only while `busy_o` is low and the pattern code is 0 to 4. A start at any other time, or with code 5 to 7, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| mode_i | input | 3 | Address pattern code |
| src_i | input | 16 | Initial source address |
| dst_i | input | 16 | Initial destination address |
| len_i | input | 16 | Byte count |
| mem_addr_o | output | 16 | Memory address; 0 when no access is made |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, combinational from `mem_addr_o` |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cost_o | output | 32 | Cycle cost tally |

## Verification
The engine is run once with each of the five pattern codes. The read data is a function of the address, so any wrong read address shows up as wrong write data.

- Code 0 uses an odd length, so a pattern that toggles between two addresses cannot pass for a steady increment.
- The decrementing run starts close enough to 0x0000 to wrap below it.
- The two toggling patterns start at 0xFFFF, which separates a 16-bit wrap from a carry into a wider address.
- Code 2 must keep the same write address for every byte.

A zero-length start, a start issued mid-transfer and a start with an undefined code show that only legal, idle starts have any effect.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    MODE_INC_INC = 3'd0,
    MODE_DEC_DEC = 3'd1,
    MODE_INC_FIX = 3'd2,
    MODE_INC_ALT = 3'd3,
    MODE_ALT_INC = 3'd4
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_e;

  function automatic logic mode_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
  import xfer_pkg::*;
#(
  parameter int AW = 16
) (
  input  xfer_mode_e     mode_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic           alt_i,
  output logic [AW-1:0]  rd_addr_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [AW-1:0]  src_nxt_o,
  output logic [AW-1:0]  dst_nxt_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] alt_ext;
  assign alt_ext = {{(AW-1){1'b0}}, alt_i};

  // all sums are AW bits wide, so wrap is modulo 2^AW
  always_comb begin
    rd_addr_o = src_i;
    wr_addr_o = dst_i;
    src_nxt_o = src_i + ONE;
    dst_nxt_o = dst_i + ONE;
    case (mode_i)
      MODE_DEC_DEC: begin
        src_nxt_o = src_i - ONE;
        dst_nxt_o = dst_i - ONE;
      end
      MODE_INC_FIX: dst_nxt_o = dst_i;
      MODE_INC_ALT: begin
        wr_addr_o = dst_i + alt_ext;
        dst_nxt_o = dst_i;
      end
      MODE_ALT_INC: begin
        rd_addr_o = src_i + alt_ext;
        src_nxt_o = src_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [LW-1:0] len_i,
  output logic          rd_o,
  output logic          wr_o,
  output logic          done_o,
  output logic          busy_o
);

  localparam logic [LW-1:0] CNT_ONE = LW'(1);

  xfer_state_e   state_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_i) begin
          cnt_q   <= len_i;
          state_q <= (len_i == '0) ? ST_DONE : ST_READ;
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
          cnt_q   <= cnt_q - CNT_ONE;
          state_q <= (cnt_q == CNT_ONE) ? ST_DONE : ST_READ;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o   = (state_q == ST_READ);
  assign wr_o   = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE);

  p_cnt_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> (cnt_q != '0));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read_to_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);

endmodule

// File: rtl/xfer_cost.sv
module xfer_cost #(
  parameter int CW         = 32,
  parameter int SETUP_COST = 17,
  parameter int BYTE_COST  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          step_i,
  output logic [CW-1:0] cost_o
);

  localparam logic [CW-1:0] SETUP_V = CW'(SETUP_COST);
  localparam logic [CW-1:0] BYTE_V  = CW'(BYTE_COST);

  logic [CW-1:0] cost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cost_q <= '0;
    else if (launch_i) cost_q <= SETUP_V;
    else if (step_i)   cost_q <= cost_q + BYTE_V;
  end

  assign cost_o = cost_q;

  p_cost_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !launch_i) |=> (cost_o == $past(cost_o) + BYTE_V));
  p_cost_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !launch_i) |=> $stable(cost_o));

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import xfer_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LW         = 16,
  parameter int DW         = 8,
  parameter int CW         = 32,
  parameter int SETUP_COST = 17,
  parameter int BYTE_COST  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cost_o
);

  logic          launch;
  logic          rd, wr, done, busy;
  xfer_mode_e    mode_q;
  logic [AW-1:0] src_q, dst_q;
  logic          alt_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] rd_addr, wr_addr, src_nxt, dst_nxt;

  assign launch = start_i && !busy && mode_legal(mode_i);

  xfer_seq #(.LW(LW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .len_i    (len_i),
    .rd_o     (rd),
    .wr_o     (wr),
    .done_o   (done),
    .busy_o   (busy)
  );

  xfer_addr_gen #(.AW(AW)) u_addr (
    .mode_i    (mode_q),
    .src_i     (src_q),
    .dst_i     (dst_q),
    .alt_i     (alt_q),
    .rd_addr_o (rd_addr),
    .wr_addr_o (wr_addr),
    .src_nxt_o (src_nxt),
    .dst_nxt_o (dst_nxt)
  );

  xfer_cost #(.CW(CW), .SETUP_COST(SETUP_COST), .BYTE_COST(BYTE_COST)) u_cost (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .step_i   (wr),
    .cost_o   (cost_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_INC_INC;
      src_q  <= '0;
      dst_q  <= '0;
      alt_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (launch) begin
        mode_q <= xfer_mode_e'(mode_i);
        src_q  <= src_i;
        dst_q  <= dst_i;
        alt_q  <= 1'b0;
      end else if (wr) begin
        src_q  <= src_nxt;
        dst_q  <= dst_nxt;
        alt_q  <= ~alt_q;
      end
      if (rd) data_q <= mem_rdata_i;
    end
  end

  assign mem_rd_o    = rd;
  assign mem_wr_o    = wr;
  assign mem_addr_o  = rd ? rd_addr : (wr ? wr_addr : '0);
  assign mem_wdata_o = data_q;
  assign busy_o      = busy;
  assign done_o      = done;

  p_rd_wr_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  p_wdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wdata_o == $past(mem_rdata_i)));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !mem_wr_o));
  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_fix_dst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mode_q == MODE_INC_FIX && $past(mem_wr_o, 2))
      |-> (mem_addr_o == $past(mem_addr_o, 2)));

endmodule

// File: tb/tb_blk_xfer_engine.sv
`timescale 1ns/1ps
module tb_blk_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] src = '0, dst = '0, len = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [31:0] cost;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  blk_xfer_engine dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .mode_i (mode),
    .src_i (src), .dst_i (dst), .len_i (len),
    .mem_addr_o (mem_addr), .mem_rd_o (mem_rd), .mem_wr_o (mem_wr),
    .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
    .busy_o (busy), .done_o (done), .cost_o (cost)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rd(input int m, input logic [15:0] s, input int i);
    case (m)
      1:       return s - 16'(i);
      4:       return s + 16'(i % 2);
      default: return s + 16'(i);
    endcase
  endfunction

  function automatic logic [15:0] ref_wr(input int m, input logic [15:0] d, input int i);
    case (m)
      1:       return d - 16'(i);
      2:       return d;
      3:       return d + 16'(i % 2);
      default: return d + 16'(i);
    endcase
  endfunction

  // behavioural reference: per-cycle expected port trace of a transfer
  task automatic run_xfer(input int m, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] n_len, input string tag, input bit poke);
    int n = int'(n_len);
    @(negedge clk);
    start = 1'b1; mode = 3'(m); src = s; dst = d; len = n_len;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 2*n + 2; c++) begin
      logic [27:0] exp_v, act_v;
      logic        e_busy, e_done, e_rd, e_wr;
      logic [15:0] e_addr;
      logic [7:0]  e_data;
      if (c > 1) @(negedge clk);
      e_busy = 0; e_done = 0; e_rd = 0; e_wr = 0; e_addr = '0; e_data = '0;
      if (c <= 2*n) begin
        int i = (c - 1) / 2;
        e_busy = 1;
        if (c % 2 == 1) begin
          e_rd = 1; e_addr = ref_rd(m, s, i);
        end else begin
          e_wr = 1; e_addr = ref_wr(m, d, i); e_data = pat(ref_rd(m, s, i));
        end
      end else if (c == 2*n + 1) begin
        e_busy = 1; e_done = 1;
      end
      exp_v = {e_busy, e_done, e_rd, e_wr, e_addr, e_data};
      act_v = {busy, done, mem_rd, mem_wr, mem_addr, mem_wr ? mem_wdata : 8'h00};
      check(act_v == exp_v, (c == 2*n + 1) ? {"R10 ", tag} : {"R2 ", tag},
            32'(act_v), 32'(exp_v));
      if (c >= 2*n + 1)
        check(cost == 32'(17 + 6*n), {"R11 ", tag}, cost, 32'(17 + 6*n));
      if (poke && c == 2) begin
        start = 1'b1; mode = 3'd1; src = 16'hAAAA; dst = 16'h5555; len = 16'd9;
      end
      if (poke && c == 3) start = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, mem_rd, mem_wr} == 4'b0, "R1 strobes", {28'b0, busy, done, mem_rd, mem_wr}, 32'h0);
    check(cost == 32'h0, "R1 cost", cost, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd && !mem_wr, "R1 idle after release", {29'b0, busy, mem_rd, mem_wr}, 32'h0);

    run_xfer(0, 16'h1000, 16'h2000, 16'd5, "R3 inc/inc", 1'b0);
    run_xfer(1, 16'h0002, 16'h0101, 16'd4, "R4 R8 dec/dec", 1'b0);
    run_xfer(2, 16'h0300, 16'h0ABC, 16'd3, "R5 inc/fixed", 1'b0);
    run_xfer(3, 16'hFFFE, 16'hFFFF, 16'd5, "R6 R8 inc/alt", 1'b0);
    run_xfer(4, 16'hFFFF, 16'hFFFE, 16'd4, "R7 R8 alt/inc", 1'b0);
    run_xfer(0, 16'h1234, 16'h4321, 16'd0, "R9 zero length", 1'b0);
    run_xfer(0, 16'h0040, 16'h0080, 16'd3, "R12 start while busy", 1'b1);

    // R12 illegal pattern code
    for (int code = 5; code <= 7; code++) begin
      @(negedge clk);
      start = 1'b1; mode = 3'(code); src = 16'h0010; dst = 16'h0020; len = 16'd2;
      @(negedge clk);
      start = 1'b0;
      check(!busy && !mem_rd && !mem_wr, "R12 illegal code ignored",
            {29'b0, busy, mem_rd, mem_wr}, 32'h0);
      check(cost == 32'd35, "R12 cost untouched", cost, 32'd35);
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule